// File: doc/BRIEF.md
# Bit-Sliced Serial Data Router

The block moves single bits from sixteen source shift registers into sixteen destination shift registers over one shared bit line. The sources are split into two banks of eight. Each bank has an eight-way bit selector, and only the bank chosen by the top bit of the source select may drive the shared line. A destination address is decoded to a one-hot enable. On a transfer strobe, the addressed destination register takes the line value into its least significant bit.

An external sequencer supplies the selects, the addresses and the shift enables. The order in which it steps through sources and destinations sets the data pattern. One pattern sends each source's bits into a destination of its own. Another reslices the data: it gathers the current top bit of every source into one destination, shifts all sources, and then gathers the next bit column into the next destination. The selects can be stepped much faster than the sources shift, so a whole column is collected before the sources move on.

Top module: `bit_slice_router`

## Requirements
- R1: While rst_ni is low, every source register and every destination register is cleared to zero.
- R2: When load_i is high at a clock edge, source register k takes load_data_i[k*IN_W +: IN_W] for every k. A load takes priority over a shift in the same cycle.
- R3: When load_i is low and shift_en_i[k] is high, source register k shifts one place toward its MSB and takes 0 into its LSB. A source register whose shift enable is low holds its value.
- R4: The shared bit is the MSB of source register 8*src_sel_i[3] + src_sel_i[2:0]. Bit 3 enables the bank that holds sources 8 to 15 when it is 1, and the bank that holds sources 0 to 7 when it is 0. The other bank contributes 0.
- R5: On a clock edge with strobe_i high, destination register dst_addr_i, found at out_regs_o[dst_addr_i*OUT_W +: OUT_W], shifts one place toward its MSB and takes the shared bit into its LSB.
- R6: A destination register that is not addressed, or any destination register on an edge without the strobe, keeps its value.
- R7: A transfer on the same edge as a load or shift of the sources uses the source MSB as it was before that edge.
- R8: Loading the sixteen sources and then running IN_W rounds does the following in round b: it transfers sources 0 to 15 in order into destination b and then shifts every source once. Afterwards, with OUT_W = 16, bit 15-s of destination b equals bit IN_W-1-b of the word loaded into source s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Parallel load of all source registers |
| load_data_i | input | 16*IN_W | Load words; source k in slice k |
| shift_en_i | input | 16 | Per-source shift enable |
| src_sel_i | input | 4 | Bank select (bit 3) and bit index inside the bank (bits 2:0) |
| dst_addr_i | input | 4 | Destination register address |
| strobe_i | input | 1 | Transfer strobe |
| out_regs_o | output | 16*OUT_W | Destination register contents; register j in slice j |

## Verification
The properties assume that every control input is a known value at each rising edge. They also assume that IN_W and OUT_W are at least 2, so that a shift always has a bit to move. The stimulus changes inputs only at the falling edge, never leaves a select or address undriven, and uses all sixteen select codes, so no out-of-range index can occur. Every cycle is compared against a register model built from the requirements. The slicing sweep and the per-source sweep are also checked against bit columns computed directly from the loaded words.

// File: rtl/brt_pkg.sv
`timescale 1ns/1ps
package brt_pkg;
  localparam int NUM_SRC   = 16;
  localparam int GRP_SZ    = 8;
  localparam int NUM_GRP   = NUM_SRC / GRP_SZ;
  localparam int SEL_W     = $clog2(GRP_SZ);
  localparam int SRC_W     = $clog2(NUM_SRC);
  localparam int GRP_IDX_W = SRC_W - SEL_W;
  localparam int NUM_DST   = 16;
  localparam int DST_W     = $clog2(NUM_DST);
endpackage

// File: rtl/brt_src_bank.sv
`timescale 1ns/1ps
module brt_src_bank #(
  parameter int W = 8,
  parameter int N = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [N*W-1:0] load_data_i,
  input  logic [N-1:0]   shift_en_i,
  output logic [N*W-1:0] regs_o,
  output logic [N-1:0]   msb_o
);
  for (genvar k = 0; k < N; k++) begin : g_src
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            q <= '0;
      else if (load_i)        q <= load_data_i[k*W +: W];
      else if (shift_en_i[k]) q <= {q[W-2:0], 1'b0};
    end
    assign regs_o[k*W +: W] = q;
    assign msb_o[k]         = q[W-1];
  end
endmodule

// File: rtl/brt_grp_sel.sv
`timescale 1ns/1ps
module brt_grp_sel #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  input  logic [IW-1:0] idx_i,
  input  logic          en_i,
  output logic          bit_o
);
  // a disabled bank drives 0 so that the shared line can be an OR
  always_comb bit_o = en_i & bits_i[idx_i];
endmodule

// File: rtl/brt_dst_dist.sv
`timescale 1ns/1ps
module brt_dst_dist #(
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic [AW-1:0] addr_i,
  input  logic          strobe_i,
  input  logic          bit_i,
  output logic [N-1:0]  en_o,
  output logic [N-1:0]  line_o
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      en_o[i]   = strobe_i && (addr_i == AW'(i));
      line_o[i] = en_o[i] & bit_i;  // data rides the gate path
    end
  end
endmodule

// File: rtl/brt_dst_bank.sv
`timescale 1ns/1ps
module brt_dst_bank #(
  parameter int W = 16,
  parameter int N = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   en_i,
  input  logic [N-1:0]   line_i,
  output logic [N*W-1:0] regs_o
);
  for (genvar j = 0; j < N; j++) begin : g_dst
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (en_i[j]) q <= {q[W-2:0], line_i[j]};
    end
    assign regs_o[j*W +: W] = q;
  end
endmodule

// File: rtl/bit_slice_router.sv
`timescale 1ns/1ps
module bit_slice_router
  import brt_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [NUM_SRC*IN_W-1:0]  load_data_i,
  input  logic [NUM_SRC-1:0]       shift_en_i,
  input  logic [SRC_W-1:0]         src_sel_i,
  input  logic [DST_W-1:0]         dst_addr_i,
  input  logic                     strobe_i,
  output logic [NUM_DST*OUT_W-1:0] out_regs_o
);
  logic [NUM_SRC*IN_W-1:0] in_regs;
  logic [NUM_SRC-1:0]      src_msb;
  logic [NUM_GRP-1:0]      grp_bit;
  logic                    bus_bit;
  logic [NUM_DST-1:0]      dst_en;
  logic [NUM_DST-1:0]      dst_line;

  brt_src_bank #(.W(IN_W), .N(NUM_SRC)) u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_data_i (load_data_i),
    .shift_en_i  (shift_en_i),
    .regs_o      (in_regs),
    .msb_o       (src_msb)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    brt_grp_sel #(.N(GRP_SZ)) u_sel (
      .bits_i (src_msb[g*GRP_SZ +: GRP_SZ]),
      .idx_i  (src_sel_i[SEL_W-1:0]),
      .en_i   (src_sel_i[SRC_W-1:SEL_W] == GRP_IDX_W'(g)),
      .bit_o  (grp_bit[g])
    );
  end

  assign bus_bit = |grp_bit;

  brt_dst_dist #(.N(NUM_DST)) u_dist (
    .addr_i   (dst_addr_i),
    .strobe_i (strobe_i),
    .bit_i    (bus_bit),
    .en_o     (dst_en),
    .line_o   (dst_line)
  );

  brt_dst_bank #(.W(OUT_W), .N(NUM_DST)) u_dst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (dst_en),
    .line_i (dst_line),
    .regs_o (out_regs_o)
  );
endmodule

// File: rtl/brt_checker.sv
`timescale 1ns/1ps
module brt_checker
  import brt_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     load_i,
  input logic [NUM_SRC*IN_W-1:0]  load_data_i,
  input logic [NUM_SRC-1:0]       shift_en_i,
  input logic [SRC_W-1:0]         src_sel_i,
  input logic [DST_W-1:0]         dst_addr_i,
  input logic                     strobe_i,
  input logic [NUM_DST*OUT_W-1:0] out_regs_o,
  input logic [NUM_SRC*IN_W-1:0]  in_regs,
  input logic [NUM_SRC-1:0]       src_msb,
  input logic                     bus_bit
);
  logic [NUM_SRC*IN_W-1:0]  in_shl;
  logic [NUM_DST*OUT_W-1:0] addr_mask;
  logic [NUM_DST*OUT_W-1:0] out_next;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_k
    assign in_shl[k*IN_W +: IN_W] = {in_regs[k*IN_W +: IN_W-1], 1'b0};

    a_r3_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && shift_en_i[k]) |=> in_regs[k*IN_W +: IN_W] == $past(in_shl[k*IN_W +: IN_W]));

    a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !shift_en_i[k]) |=> $stable(in_regs[k*IN_W +: IN_W]));
  end

  for (genvar j = 0; j < NUM_DST; j++) begin : g_j
    assign addr_mask[j*OUT_W +: OUT_W] = {OUT_W{dst_addr_i == DST_W'(j)}};
    assign out_next[j*OUT_W +: OUT_W]  = {out_regs_o[j*OUT_W +: OUT_W-1], bus_bit};
  end

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> in_regs == $past(load_data_i));

  a_r4_bus_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_bit == src_msb[src_sel_i]);

  a_r5_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (out_regs_o & $past(addr_mask)) == $past(out_next & addr_mask));

  a_r6_others_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> ((out_regs_o ^ $past(out_regs_o)) & ~$past(addr_mask)) == '0);

  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(out_regs_o));
endmodule

bind bit_slice_router brt_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .load_data_i (load_data_i),
  .shift_en_i  (shift_en_i),
  .src_sel_i   (src_sel_i),
  .dst_addr_i  (dst_addr_i),
  .strobe_i    (strobe_i),
  .out_regs_o  (out_regs_o),
  .in_regs     (in_regs),
  .src_msb     (src_msb),
  .bus_bit     (bus_bit)
);

// File: tb/bit_slice_router_test.sv
`timescale 1ns/1ps
module bit_slice_router_test;
  localparam int IN_W  = 8;
  localparam int OUT_W = 16;
  localparam int NS    = 16;
  localparam int ND    = 16;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 load_i = 1'b0;
  logic [NS*IN_W-1:0]   load_data_i = '0;
  logic [NS-1:0]        shift_en_i = '0;
  logic [3:0]           src_sel_i = '0;
  logic [3:0]           dst_addr_i = '0;
  logic                 strobe_i = 1'b0;
  logic [ND*OUT_W-1:0]  out_regs_o;

  int checks = 0;
  int errors = 0;
  logic [IN_W-1:0]  m_in  [NS];
  logic [OUT_W-1:0] m_out [ND];
  logic [IN_W-1:0]  words [NS];

  always #2.5 clk_i = ~clk_i;

  bit_slice_router #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (
    .clk_i, .rst_ni, .load_i, .load_data_i, .shift_en_i,
    .src_sel_i, .dst_addr_i, .strobe_i, .out_regs_o
  );

  task automatic cmp_all(input string tag);
    int bad = -1;
    checks++;
    for (int j = 0; j < ND; j++)
      if (bad < 0 && out_regs_o[j*OUT_W +: OUT_W] !== m_out[j]) bad = j;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s dst %0d actual %h expected %h", tag, bad,
               out_regs_o[bad*OUT_W +: OUT_W], m_out[bad]);
    end
  endtask

  // drive at the falling edge, let one rising edge pass, compare at the next falling edge
  task automatic step(input logic ld, input logic [NS-1:0] sh, input logic [3:0] sel,
                      input logic [3:0] addr, input logic stb, input string tag);
    logic b;
    load_i = ld; shift_en_i = sh; src_sel_i = sel; dst_addr_i = addr; strobe_i = stb;
    b = m_in[sel][IN_W-1];  // R4, R7: pre-edge MSB
    if (stb) m_out[addr] = {m_out[addr][OUT_W-2:0], b};
    for (int k = 0; k < NS; k++) begin
      if (ld) m_in[k] = load_data_i[k*IN_W +: IN_W];
      else if (sh[k]) m_in[k] = {m_in[k][IN_W-2:0], 1'b0};
    end
    @(negedge clk_i);
    load_i = 1'b0; shift_en_i = '0; strobe_i = 1'b0;
    cmp_all(tag);
  endtask

  task automatic set_words(input int seed);
    for (int s = 0; s < NS; s++) begin
      words[s] = IN_W'((s * 37 + seed) ^ (s << 3));
      load_data_i[s*IN_W +: IN_W] = words[s];
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NS; k++) m_in[k] = '0;
    for (int j = 0; j < ND; j++) m_out[j] = '0;
    repeat (3) @(negedge clk_i);
    cmp_all("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: sources cleared -> transfers move zeros
    for (int s = 0; s < NS; s++) step(0, '0, 4'(s), 4'(s), 1, "R1 src zero");

    // R2, R4, R5, R6: load and scatter MSBs from both banks
    set_words(11);
    step(1, '0, 4'd0, 4'd0, 0, "R2 load");
    for (int s = 0; s < NS; s++) step(0, '0, 4'(s), 4'((s * 5) % 16), 1, "R4 R5 scatter");

    // R6: no strobe while select and address change
    for (int s = 0; s < 8; s++) step(0, '0, 4'(15 - s), 4'(s), 0, "R6 idle");

    // R3: shift odd sources only, then read all MSBs
    step(0, 16'hAAAA, 4'd0, 4'd0, 0, "R3 shift");
    for (int s = 0; s < NS; s++) step(0, '0, 4'(s), 4'd3, 1, "R3 read back");

    // R2: load wins over shift
    set_words(90);
    step(1, 16'hFFFF, 4'd0, 4'd0, 0, "R2 priority");
    for (int s = 0; s < NS; s++) step(0, '0, 4'(s), 4'd7, 1, "R2 read back");

    // R8, R7: column slicing, last transfer of each round shares the edge with the shift
    set_words(53);
    step(1, '0, 4'd0, 4'd0, 0, "R2 load");
    for (int b = 0; b < IN_W; b++)
      for (int s = 0; s < NS; s++)
        step(0, (s == NS - 1) ? 16'hFFFF : 16'h0000, 4'(s), 4'(b), 1, "R7 R8 sweep");
    for (int b = 0; b < IN_W; b++) begin
      logic [OUT_W-1:0] e = '0;
      for (int s = 0; s < NS; s++) e[OUT_W-1-s] = words[s][IN_W-1-b];
      checks++;
      if (out_regs_o[b*OUT_W +: OUT_W] !== e) begin
        errors++;
        $display("FAIL R8 column %0d actual %h expected %h", b, out_regs_o[b*OUT_W +: OUT_W], e);
      end
    end

    // R5: each source streamed whole into its own destination
    set_words(200);
    step(1, '0, 4'd0, 4'd0, 0, "R2 load");
    for (int b = 0; b < IN_W; b++)
      for (int s = 0; s < NS; s++)
        step(0, (s == NS - 1) ? 16'hFFFF : 16'h0000, 4'(s), 4'(s), 1, "R5 stream");
    for (int s = 0; s < NS; s++) begin
      checks++;
      if (out_regs_o[s*OUT_W +: IN_W] !== words[s]) begin
        errors++;
        $display("FAIL R5 stream dst %0d actual %h expected %h", s, out_regs_o[s*OUT_W +: IN_W], words[s]);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule